// File: doc/BRIEF.md
# GPIO port interrupt and pull control

This block serves one group of eight general-purpose pins. Through a 16-bit register bus it holds, for each pin, a pull-resistor enable and a pull direction, an edge choice, and an interrupt enable. From these bits it drives the pull-up and pull-down controls of each pad. A pull is applied only while the pin is a plain input: when its output driver is on, or when a peripheral function has taken the pin, no pull is applied.

The pad inputs pass through a two-flop synchronizer. Each pin then watches for its selected edge, rising or falling, and sets a sticky flag when that edge arrives. Software clears a flag by writing 1 to it. A pin handed to a peripheral never sets a flag. One interrupt request line is the OR, over all pins, of each flag ANDed with that pin's enable. When a new edge and a clear hit the same flag in the same cycle, the edge wins, so the event is not lost.

Top module: `gpio_pinbank`

## Requirements
- R1: After reset every register reads 0x0000, both pull outputs are 0 for every pin, and `irq` is 0.
- R2: Address 0 holds the pull register: bits 15–8 are the pull direction (1 = up, 0 = down) and bits 7–0 are the pull enables. Address 1 holds the interrupt control register: bits 15–8 are the edge choice (1 = falling, 0 = rising) and bits 7–0 are the interrupt enables. Both read back the value last written.
- R3: For a pin with no output drive and no peripheral function, `pull_up_en` is 1 when its enable and direction are both 1, and `pull_dn_en` is 1 when its enable is 1 and its direction is 0. With the enable at 0 both are 0. The two are never 1 together.
- R4: While `out_en` of a pin is 1, both of its pull outputs are 0, whatever the pull bits hold.
- R5: While `func_sel` of a pin is 1 (peripheral owns the pin), both of its pull outputs are 0, whatever the pull bits hold.
- R6: A pin in rising mode sets its flag on a 0-to-1 pad change and not on a 1-to-0 change. A pin in falling mode does the reverse. The flag can be read at address 2, bit n for pin n, once the third rising clock edge after the pad change has passed.
- R7: A flag is set whether or not its interrupt enable is 1. A pin whose `func_sel` is 1 never sets its flag.
- R8: A write to address 2 clears each flag whose data bit 7–0 is 1 and leaves alone each flag whose data bit is 0.
- R9: Bits 15–8 of address 2 always read 0, and writes to them change nothing.
- R10: `irq` is 1 exactly when at least one pin has both its flag and its interrupt enable at 1.
- R11: When an edge event and a clearing write reach the same flag in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 pull, 1 interrupt control, 2 flags) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| pad_in | input | 8 | Pad input values, asynchronous |
| out_en | input | 8 | Per-pin output driver enable |
| func_sel | input | 8 | Per-pin peripheral function select (1 = peripheral owns the pin) |
| pull_up_en | output | 8 | Per-pin pull-up enable to the pad |
| pull_dn_en | output | 8 | Per-pin pull-down enable to the pad |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sweeps every pull setting against the output-drive and peripheral gates, so a design that forgets either gate would pull against its own driver or a peripheral and mismatch there. Each pin is run through both edge modes with both edge directions, which catches swapped edge polarity, a wrong pin mapping, or an extra cycle of synchronizer latency. The flag tests write zeros and the reserved high byte to show that only written ones clear. They also land a clearing write on the very cycle an edge is detected, where a clear-wins design would lose the event. Peripheral-owned pins are toggled to confirm that they raise no flag, and `irq` is checked both with a masked flag and with an enabled flag, so an ungated OR of the flags shows up.

// File: rtl/gpio_pinbank_pkg.sv
package gpio_pinbank_pkg;

  // Register addresses on the 2-bit bus
  typedef enum logic [1:0] {
    REG_PULL   = 2'd0,
    REG_IRQCTL = 2'd1,
    REG_FLAG   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/gpio_pinbank_rst.sv
// Reset conditioner: asserts asynchronously, releases on the clock.
module gpio_pinbank_rst #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_core = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pinbank_sync.sv
// Per-pin two-flop synchronizer for the asynchronous pad inputs.
module gpio_pinbank_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_core,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [1:0] stage_q;

    always_ff @(posedge clk or negedge rst_core) begin
      if (!rst_core) stage_q <= '0;
      else           stage_q <= {stage_q[0], d[i]};
    end

    assign q[i] = stage_q[1];
  end

endmodule

// File: rtl/gpio_pinbank_pull.sv
// Pull resolution: a pin is pulled only while it is a plain input.
module gpio_pinbank_pull #(
  parameter int NPIN = 8
) (
  input  logic [NPIN-1:0] pull_on,
  input  logic [NPIN-1:0] pull_up_sel,
  input  logic [NPIN-1:0] out_en,
  input  logic [NPIN-1:0] func_sel,
  output logic [NPIN-1:0] up,
  output logic [NPIN-1:0] dn
);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic free_input;
    assign free_input = ~out_en[i] & ~func_sel[i];
    assign up[i] = pull_on[i] &  pull_up_sel[i] & free_input;
    assign dn[i] = pull_on[i] & ~pull_up_sel[i] & free_input;
  end

endmodule

// File: rtl/gpio_pinbank_edge.sv
// Edge detection and sticky flags; a set beats a clear in the same cycle.
module gpio_pinbank_edge #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_core,
  input  logic [NPIN-1:0] level,
  input  logic [NPIN-1:0] fall_mode,
  input  logic [NPIN-1:0] gpio_mode,
  input  logic [NPIN-1:0] clr_mask,
  output logic [NPIN-1:0] flags
);

  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] flag_q;
  logic [NPIN-1:0] flag_d;
  logic [NPIN-1:0] hit;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic rise_i;
    logic fall_i;
    assign rise_i = level[i] & ~prev_q[i];
    assign fall_i = ~level[i] & prev_q[i];
    assign hit[i] = gpio_mode[i] & (fall_mode[i] ? fall_i : rise_i);
  end

  always_comb begin
    flag_d = (flag_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= level;
      flag_q <= flag_d;
    end
  end

  assign flags = flag_q;

endmodule

// File: rtl/gpio_pinbank.sv
module gpio_pinbank
  import gpio_pinbank_pkg::*;
#(
  parameter int NPIN = 8,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  input  logic [NPIN-1:0] out_en,
  input  logic [NPIN-1:0] func_sel,
  output logic [NPIN-1:0] pull_up_en,
  output logic [NPIN-1:0] pull_dn_en,
  output logic            irq
);

  localparam int HALF = DW / 2;

  logic rst_core;

  logic [NPIN-1:0] pull_on_q,  pull_on_d;
  logic [NPIN-1:0] pull_dir_q, pull_dir_d;
  logic [NPIN-1:0] fall_q,     fall_d;
  logic [NPIN-1:0] ie_q,       ie_d;
  logic            pull_ce, ctl_ce;

  logic            wr_pull, wr_ctl, wr_flag;
  logic [NPIN-1:0] clr_mask;
  logic [NPIN-1:0] pad_sync;
  logic [NPIN-1:0] flags;

  gpio_pinbank_rst #(.STAGES(2)) i_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_core (rst_core)
  );

  // Write decode
  always_comb begin
    wr_pull = bus_sel && bus_wr && (reg_sel_e'(bus_addr) == REG_PULL);
    wr_ctl  = bus_sel && bus_wr && (reg_sel_e'(bus_addr) == REG_IRQCTL);
    wr_flag = bus_sel && bus_wr && (reg_sel_e'(bus_addr) == REG_FLAG);
    clr_mask = wr_flag ? bus_wdata[NPIN-1:0] : '0;
  end

  // Next state of the control registers
  always_comb begin
    pull_ce    = wr_pull;
    ctl_ce     = wr_ctl;
    pull_on_d  = bus_wdata[NPIN-1:0];
    pull_dir_d = bus_wdata[HALF +: NPIN];
    ie_d       = bus_wdata[NPIN-1:0];
    fall_d     = bus_wdata[HALF +: NPIN];
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      pull_on_q  <= '0;
      pull_dir_q <= '0;
    end else if (pull_ce) begin
      pull_on_q  <= pull_on_d;
      pull_dir_q <= pull_dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core) begin
    if (!rst_core) begin
      ie_q   <= '0;
      fall_q <= '0;
    end else if (ctl_ce) begin
      ie_q   <= ie_d;
      fall_q <= fall_d;
    end
  end

  gpio_pinbank_sync #(.W(NPIN)) i_sync (
    .clk      (clk),
    .rst_core (rst_core),
    .d        (pad_in),
    .q        (pad_sync)
  );

  gpio_pinbank_edge #(.NPIN(NPIN)) i_edge (
    .clk       (clk),
    .rst_core  (rst_core),
    .level     (pad_sync),
    .fall_mode (fall_q),
    .gpio_mode (~func_sel),
    .clr_mask  (clr_mask),
    .flags     (flags)
  );

  gpio_pinbank_pull #(.NPIN(NPIN)) i_pull (
    .pull_on     (pull_on_q),
    .pull_up_sel (pull_dir_q),
    .out_en      (out_en),
    .func_sel    (func_sel),
    .up          (pull_up_en),
    .dn          (pull_dn_en)
  );

  assign irq = |(flags & ie_q);

  // Read mux
  always_comb begin
    bus_rdata = '0;
    unique case (reg_sel_e'(bus_addr))
      REG_PULL: begin
        bus_rdata[NPIN-1:0]    = pull_on_q;
        bus_rdata[HALF +: NPIN] = pull_dir_q;
      end
      REG_IRQCTL: begin
        bus_rdata[NPIN-1:0]    = ie_q;
        bus_rdata[HALF +: NPIN] = fall_q;
      end
      REG_FLAG: bus_rdata[NPIN-1:0] = flags;
      REG_NONE: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_pinbank_chk.sv
module gpio_pinbank_chk
  import gpio_pinbank_pkg::*;
#(
  parameter int NPIN = 8,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_core,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [1:0]      bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [NPIN-1:0] out_en,
  input logic [NPIN-1:0] func_sel,
  input logic [NPIN-1:0] pull_up_en,
  input logic [NPIN-1:0] pull_dn_en,
  input logic [NPIN-1:0] flags,
  input logic [NPIN-1:0] ie,
  input logic            irq
);

  logic [NPIN-1:0] clr_seen;
  assign clr_seen = (bus_sel && bus_wr && bus_addr == REG_FLAG) ? bus_wdata[NPIN-1:0] : '0;

  assert_pull_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_core)
    (pull_up_en & pull_dn_en) == '0);

  assert_no_pull_driven_R4: assert property (@(posedge clk) disable iff (!rst_core)
    ((pull_up_en | pull_dn_en) & out_en) == '0);

  assert_no_pull_periph_R5: assert property (@(posedge clk) disable iff (!rst_core)
    ((pull_up_en | pull_dn_en) & func_sel) == '0);

  assert_periph_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_core)
    1'b1 |=> ((flags & ~$past(flags)) & $past(func_sel)) == '0);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_core)
    1'b1 |=> (($past(flags) & ~$past(clr_seen)) & ~flags) == '0);

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_core)
    (bus_addr == REG_FLAG) |-> bus_rdata[DW-1:NPIN] == '0);

  assert_irq_needs_enabled_flag_R10: assert property (@(posedge clk) disable iff (!rst_core)
    irq |-> ((flags != '0) && (ie != '0)));

endmodule

bind gpio_pinbank gpio_pinbank_chk #(.NPIN(NPIN), .DW(DW)) i_chk (
  .clk        (clk),
  .rst_core   (rst_core),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .out_en     (out_en),
  .func_sel   (func_sel),
  .pull_up_en (pull_up_en),
  .pull_dn_en (pull_dn_en),
  .flags      (flags),
  .ie         (ie_q),
  .irq        (irq)
);

// File: tb/test_gpio_pinbank.sv
`timescale 1ns/1ps
module test_gpio_pinbank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [7:0]  pad_in, out_en, func_sel;
  logic [7:0]  pull_up_en, pull_dn_en;
  logic        irq;

  int nvec  = 0;
  int nfail = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  gpio_pinbank i_gpio_pinbank (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pad_in     (pad_in),
    .out_en     (out_en),
    .func_sel   (func_sel),
    .pull_up_en (pull_up_en),
    .pull_dn_en (pull_dn_en),
    .irq        (irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pad_wait(input logic [7:0] v);
    pad_in = v;
    tick(); tick(); tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nvec++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    pad_in = 0; out_en = 0; func_sel = 0;
    @(negedge clk); tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick(); tick();

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rd(a[1:0], r); chk("R1 reg", r, 16'h0000);
    end
    chk("R1 pulls", {pull_up_en, pull_dn_en}, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 readback
    wr(2'd0, 16'hA55A); rd(2'd0, r); chk("R2 pull reg", r, 16'hA55A);
    wr(2'd1, 16'h3CC3); rd(2'd1, r); chk("R2 irqctl reg", r, 16'h3CC3);
    wr(2'd1, 16'h0000);

    // R3/R4/R5 sweep of pull settings against gates
    for (int k = 0; k < 256; k++) begin
      logic [7:0] en, dir, oe, fs, eu, ed;
      en  = k[7:0];
      dir = 8'(k * 37 + 5);
      oe  = 8'(k * 91 + 3);
      fs  = 8'(k * 53 + 11);
      if (k < 64) begin oe = 8'h00; fs = 8'h00; end
      wr(2'd0, {dir, en});
      out_en = oe; func_sel = fs;
      #1;
      eu = en & dir & ~oe & ~fs;
      ed = en & ~dir & ~oe & ~fs;
      if (k < 64) chk("R3 pull decode", {pull_up_en, pull_dn_en}, {eu, ed});
      else if (k[0]) chk("R4 out_en gate", {pull_up_en, pull_dn_en}, {eu, ed});
      else chk("R5 func_sel gate", {pull_up_en, pull_dn_en}, {eu, ed});
    end
    out_en = 0; func_sel = 0;
    wr(2'd0, 16'hFFFF); out_en = 8'hFF; #1;
    chk("R4 all driven", {pull_up_en, pull_dn_en}, 16'h0000);
    out_en = 0; func_sel = 8'hFF; #1;
    chk("R5 all periph", {pull_up_en, pull_dn_en}, 16'h0000);
    func_sel = 0;

    // R6 edge sweep per pin and mode
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 2; m++) begin
        logic [7:0] bit_p;
        bit_p = 8'(1 << p);
        wr(2'd1, {(m == 1) ? bit_p : 8'h00, 8'h00});
        wr(2'd2, 16'h00FF);
        pad_in = bit_p; tick(); tick();
        rd(2'd2, r); chk("R6 latency not early", r, 16'h0000);
        tick();
        rd(2'd2, r); chk("R6 rise", r, {8'h00, (m == 1) ? 8'h00 : bit_p});
        wr(2'd2, 16'h00FF);
        pad_wait(8'h00);
        rd(2'd2, r); chk("R6 fall", r, {8'h00, (m == 1) ? bit_p : 8'h00});
        wr(2'd2, 16'h00FF);
      end
    end

    // R7 peripheral pins never flag; flag set without enable
    wr(2'd1, 16'h0000);
    func_sel = 8'hFF;
    pad_wait(8'hFF); pad_wait(8'h00);
    rd(2'd2, r); chk("R7 periph no flag", r, 16'h0000);
    func_sel = 8'h00;
    pad_wait(8'h08);
    rd(2'd2, r); chk("R7 flag without enable", r, 16'h0008);
    chk("R10 masked flag no irq", {15'd0, irq}, 16'h0000);

    // R8/R9 write zeros and reserved bits
    wr(2'd2, 16'hFF00);
    rd(2'd2, r); chk("R8 write zero keeps flag", r, 16'h0008);
    chk("R9 reserved reads zero", {8'h00, r[15:8]}, 16'h0000);

    // R10 irq with enable
    wr(2'd1, 16'h0020);
    chk("R10 other pin enabled", {15'd0, irq}, 16'h0000);
    wr(2'd1, 16'h0008);
    chk("R10 enabled flag irq", {15'd0, irq}, 16'h0001);
    wr(2'd2, 16'h0008);
    rd(2'd2, r); chk("R8 write one clears", r, 16'h0000);
    chk("R10 irq drops", {15'd0, irq}, 16'h0000);

    // R11 set and clear in the same cycle
    pad_in = 8'h09; tick(); tick();
    wr(2'd2, 16'h0001);
    rd(2'd2, r); chk("R11 set beats clear", r, 16'h0001);
    chk("R10 not enabled pin0", {15'd0, irq}, 16'h0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule